// File: doc/BRIEF.md
# Three-wire serial register write port

This block is a write-only serial slave that fills a bank of configuration registers. Three lines drive it: a serial clock, an active-low load enable and a serial data line. Both the enable and the data line are sampled only on rising clock edges. A write frame carries a register address and then a data word, each sent most significant bit first. One more clock with the enable still low moves the shifted word, all bits at once, into the addressed register.

Every register is presented in parallel on one wide output bus, so surrounding logic can use its settings directly. In the default layout, register 2 holds an offset-compensation value and register 3 holds a gain-compensation value. A one-cycle strobe, together with the address it wrote, marks each update. There is no read path. A frame cut short is dropped. Low-enable cycles that follow a commit do nothing until the enable has gone high again.

Top module: `serreg_wr_port`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is low, every register takes its default value from `RST_VAL` (all zero by default) and `wr_stb` is 0.
- R2: A frame holds 3 address bits (a[2] first) and then 16 data bits (d[15] first), sampled on rising `sclk` edges while `load_n` is low. Register k occupies `regs_o[16*k +: 16]`.
- R3: No register changes after the 19th low-enable edge of a frame. The 20th low edge writes the word into the addressed register and raises `wr_stb`, so both are visible after that same edge.
- R4: If `load_n` returns high before the 20th low edge, the partial frame is discarded and no register changes.
- R5: After a commit, further low-enable edges are ignored until `load_n` has been sampled high at least once.
- R6: A frame starts only after at least one rising edge with `load_n` high. Low-enable edges after reset that come before any high sample are ignored.
- R7: `wr_stb` is high for exactly one cycle per commit, `wr_addr` then gives the written address, and no other register changes.
- R8: Two complete frames separated by a single high-enable edge both commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all sampling on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low load enable, idles high |
| sdin | input | 1 | Serial address/data bit |
| regs_o | output | NREG*DATA_W (128) | All registers, register k at bits [16k+15:16k] |
| wr_stb | output | 1 | One-cycle pulse when a register is written |
| wr_addr | output | 3 | Address of the register written with `wr_stb` |

## Verification
On every cycle the assertions check the following. The strobe lasts one cycle. A strobe is preceded by low-enable samples one and twenty edges back. No register moves unless a strobe accompanies the change. Only the register named by `wr_addr` may change, and reset holds the defaults. The bench scenarios are needed for the rest: the exact bit order of address and data, that nothing is written after 19 low edges, that short frames and post-commit low cycles are dropped, that nothing happens before the first high sample after reset, and that back-to-back frames both land. The scoreboard compares each strobe against the queued address and word.

// File: rtl/serreg_wr_port.sv
module serreg_wr_port #(
  parameter int NREG = 8,
  parameter int DATA_W = 16,
  parameter logic [NREG*DATA_W-1:0] RST_VAL = '0,
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int FW = AW + DATA_W,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic                   sclk,
  input  logic                   rst_n,
  input  logic                   load_n,
  input  logic                   sdin,
  output logic [NREG*DATA_W-1:0] regs_o,
  output logic                   wr_stb,
  output logic [AW-1:0]          wr_addr
);

  logic          ready;
  logic [CW-1:0] cnt;
  logic [FW-1:0] sr;

  wire          commit  = ready && !load_n && (cnt == CW'(FW));
  wire          shift   = ready && !load_n && (cnt != CW'(FW));
  wire [AW-1:0] sh_addr = sr[FW-1 -: AW];

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      cnt   <= '0;
      sr    <= '0;
    end else if (load_n) begin
      ready <= 1'b1;
      cnt   <= '0;
    end else if (commit) begin
      ready <= 1'b0;
      cnt   <= '0;
    end else if (shift) begin
      sr  <= {sr[FW-2:0], sdin};
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_stb <= commit;
      if (commit) wr_addr <= sh_addr;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)
        regs_o[g*DATA_W +: DATA_W] <= RST_VAL[g*DATA_W +: DATA_W];
      else if (commit && sh_addr == AW'(g))
        regs_o[g*DATA_W +: DATA_W] <= sr[DATA_W-1:0];
    end
  end

endmodule

module serreg_wr_port_chk #(
  parameter int NREG = 8,
  parameter int DATA_W = 16,
  parameter logic [NREG*DATA_W-1:0] RST_VAL = '0,
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic                   sclk,
  input logic                   rst_n,
  input logic                   load_n,
  input logic                   sdin,
  input logic [NREG*DATA_W-1:0] regs_o,
  input logic                   wr_stb,
  input logic [AW-1:0]          wr_addr
);

  p_reset_defaults_r1: assert property (@(posedge sclk)
    !rst_n |-> (regs_o == RST_VAL && !wr_stb));

  p_strobe_after_low_r2: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_stb |-> !$past(load_n));

  p_no_change_without_strobe_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    !wr_stb |-> $stable(regs_o));

  p_full_low_run_r4: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_stb |-> (!$past(load_n, 1) && !$past(load_n, 20)));

  p_strobe_single_r7: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    p_others_stable_r7: assert property (@(posedge sclk) disable iff (!rst_n)
      (wr_stb && wr_addr != AW'(g)) |-> $stable(regs_o[g*DATA_W +: DATA_W]));
  end

  wire unused_ok = &{1'b0, sdin};

endmodule

bind serreg_wr_port serreg_wr_port_chk #(
  .NREG(NREG), .DATA_W(DATA_W), .RST_VAL(RST_VAL)
) u_chk (.*);

// File: tb/tb_serreg_wr_port.sv
`timescale 1ns/1ps
module tb_serreg_wr_port;
  logic         sclk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_n = 1'b0;
  logic         sdin = 1'b0;
  logic [127:0] regs_o;
  logic         wr_stb;
  logic [2:0]   wr_addr;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [8];
  logic [18:0] expq [$];

  serreg_wr_port dut (.sclk(sclk), .rst_n(rst_n), .load_n(load_n), .sdin(sdin),
                      .regs_o(regs_o), .wr_stb(wr_stb), .wr_addr(wr_addr));

  always #10 sclk = ~sclk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 8; k++)
      chk(regs_o[k*16 +: 16] == model[k], req, {16'd0, regs_o[k*16 +: 16]}, {16'd0, model[k]});
  endtask

  // Scoreboard monitor
  always @(negedge sclk) begin
    if (rst_n && wr_stb) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R5/R7 unexpected strobe", {29'd0, wr_addr}, 32'hFFFF_FFFF);
      end else begin
        logic [18:0] e;
        e = expq.pop_front();
        chk(wr_addr == e[18:16], "R7 strobe address", {29'd0, wr_addr}, {29'd0, e[18:16]});
        chk(regs_o[wr_addr*16 +: 16] == e[15:0], "R2 written word",
            {16'd0, regs_o[wr_addr*16 +: 16]}, {16'd0, e[15:0]});
      end
    end
  end

  // nlow: low-enable edges driven for the frame; extra: further lows after it
  task automatic send(input logic [2:0] a, input logic [15:0] d, input int nlow, input int extra);
    logic [18:0] f;
    f = {a, d};
    if (nlow >= 20) expq.push_back(f);
    for (int i = 0; i < nlow + extra; i++) begin
      load_n = 1'b0;
      sdin = (i < 19) ? f[18 - i] : ~sdin;
      @(negedge sclk);
      if (i == 18) begin
        chk(regs_o[a*16 +: 16] == model[a] && !wr_stb, "R3 no write after 19 edges",
            {15'd0, wr_stb, regs_o[a*16 +: 16]}, {16'd0, model[a]});
      end
      if (i == 19) chk(wr_stb == 1'b1, "R3 strobe after 20th edge", {31'd0, wr_stb}, 32'd1);
    end
    if (nlow >= 20) model[a] = d;
    load_n = 1'b1;
    @(negedge sclk);
  endtask

  initial begin
    #4_000_000;
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) model[k] = 16'h0000;
    repeat (2) @(negedge sclk);
    check_all("R1 reset defaults");
    chk(!wr_stb, "R1 strobe low in reset", {31'd0, wr_stb}, 32'd0);
    // R6: release reset with enable low, never high yet
    sdin = 1'b1;
    rst_n = 1'b1;
    repeat (25) @(negedge sclk);
    check_all("R6 ignored before first high");
    load_n = 1'b1;
    @(negedge sclk);
    // R2 / R7 main writes
    send(3'd2, 16'hA5C3, 20, 0); check_all("R2 write offset reg");
    send(3'd3, 16'h1234, 20, 0); check_all("R2 write gain reg");
    send(3'd0, 16'h8001, 20, 0); check_all("R7 only addressed reg");
    send(3'd7, 16'hFFFF, 20, 0); check_all("R2 top address");
    // R4 short frames
    send(3'd5, 16'hBEEF, 12, 0); check_all("R4 short frame 12");
    send(3'd5, 16'hBEEF, 19, 0); check_all("R4 short frame 19");
    send(3'd1, 16'h0F0F, 2,  0); check_all("R4 short frame 2");
    // R5 extra lows after commit
    send(3'd4, 16'h5A5A, 20, 25); check_all("R5 lows after commit ignored");
    // R8 back to back with single high between (send ends with one high)
    send(3'd6, 16'hC0DE, 20, 0);
    send(3'd6, 16'h7E57, 20, 0); check_all("R8 back to back");
    send(3'd1, 16'h0001, 20, 0); check_all("R8 next frame");
    repeat (3) @(negedge sclk);
    chk(expq.size() == 0, "R3 all commits seen", expq.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule